// File: doc/BRIEF.md
# Supply Measurement ADC Sequencer

This block runs the fixed two-step measurement that reads the internal divided-down supply voltage through an ADC. A one-cycle start request launches the run. The block first converts the reference channel. It then moves the ADC input multiplexer to the supply-monitor channel and turns on the internal input buffer. It holds that selection for a programmable settling interval so the sampling capacitor can charge to the divided supply. Only then does it start a second conversion with a fixed control word.

Both 12-bit codes are held at the outputs, and a one-cycle done pulse marks the end of a run. Each conversion is a one-cycle start pulse followed by a wait for a one-cycle ready pulse from the ADC. If ready does not come within a programmable window, the sequencer gives up, returns to idle and raises an error flag. Converting codes into volts is left to the consumer of the two results.

Top module: `supply_meas_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and adc_start_o are 0, and both result codes are 0.
- R2: A start_i sampled high while idle makes busy_o high in the next cycle. In that same cycle the block issues a one-cycle adc_start_o with mux_sel_o equal to REF_SEL (default 5'b11111) and ctrl_o equal to REF_CTRL (default 16'h2A83). This reference conversion always comes before any supply-channel selection.
- R3: From the cycle after the reference ready until the supply conversion completes, mux_sel_o is 5'b10011 and buf_en_o is 1. Outside that phase, buf_en_o is 0.
- R4: The supply-channel adc_start_o rises in the cycle that follows exactly SETTLE_CYC cycles with the supply channel selected and no start pulse. The default is 6000 cycles, which is 60 µs at 100 MHz.
- R5: During the supply conversion, ctrl_o is 16'h2AA3.
- R6: ref_code_o takes adc_data_i on the reference ready, and sup_code_o takes it on the supply ready. Each holds its value until its next capture.
- R7: done_o is high for exactly one cycle, in the cycle after the supply ready is sampled. busy_o falls in the cycle after done_o.
- R8: A start_i arriving while busy_o is high is ignored. The run continues unchanged, and no new run follows.
- R9: An adc_ready_i outside the two ready-wait phases is ignored. It changes neither result nor the settling length.
- R10: If no ready arrives within TIMEOUT_CYC cycles of a wait phase, the block returns to idle with err_o high and gives no done pulse. err_o clears when the next start is accepted.
- R11: A ready that arrives in the last cycle of the timeout window is accepted as a normal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a measurement run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: both codes valid |
| err_o | output | 1 | Last run ended on a ready timeout |
| mux_sel_o | output | 5 | ADC input channel select |
| buf_en_o | output | 1 | Internal input buffer enable |
| ctrl_o | output | 16 | ADC control word |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_ready_i | input | 1 | One-cycle conversion complete from the ADC |
| adc_data_i | input | 12 | Conversion result, valid with adc_ready_i |
| ref_code_o | output | 12 | Reference conversion code |
| sup_code_o | output | 12 | Supply-channel conversion code |

## Verification
The assertions assume the ADC gives a single-cycle ready pulse, with valid data in that same cycle, and never more than one ready per conversion start. They also assume start requests are pulses rather than levels. The directed stimulus follows this model: every ready and every start lasts exactly one cycle. Stray readies and early starts are injected only as single pulses in phases where the block must ignore them, so the done-follows-ready and settling-count properties stay inside their assumptions.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REF_GO,
        S_REF_WAIT,
        S_SETTLE,
        S_SUP_GO,
        S_SUP_WAIT,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       err;
    } seq_regs_t;

    localparam int N_SLOT   = 2;
    localparam int SLOT_REF = 0;
    localparam int SLOT_SUP = 1;

endpackage

// File: rtl/smseq_timer.sv
module smseq_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R4 / R10: an idle timer must not wrap around to a large value
    p_hold_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/smseq_result.sv
module smseq_result #(
    parameter int DATA_W = 12,
    parameter int SLOTS  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SLOTS-1:0]             cap_i,
    input  logic [DATA_W-1:0]            data_i,
    output logic [SLOTS-1:0][DATA_W-1:0] codes_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (cap_i[g]) code_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_q <= '0;
            else        code_q <= code_d;
        end

        assign codes_o[g] = code_q;

        // R6: a slot keeps its code between captures
        p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_i[g] |=> $stable(codes_o[g]));
    end

endmodule

// File: rtl/supply_meas_seq.sv
module supply_meas_seq
    import smseq_pkg::*;
#(
    parameter int          DATA_W      = 12,
    parameter int          CH_W        = 5,
    parameter int          CTRL_W      = 16,
    parameter int          SETTLE_CYC  = 6000,
    parameter int          TIMEOUT_CYC = 4096,
    parameter logic [4:0]  REF_SEL     = 5'b11111,
    parameter logic [4:0]  SUP_SEL     = 5'b10011,
    parameter logic [15:0] REF_CTRL    = 16'h2A83,
    parameter logic [15:0] SUP_CTRL    = 16'h2AA3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CH_W-1:0]   mux_sel_o,
    output logic              buf_en_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              adc_start_o,
    input  logic              adc_ready_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic [DATA_W-1:0] ref_code_o,
    output logic [DATA_W-1:0] sup_code_o
);
    localparam int MAX_CYC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TOUT_LD   = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W:0]   SETTLE_CHK = (CNT_W + 1)'(SETTLE_CYC);

    seq_regs_t          r_d, r_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [N_SLOT-1:0]  cap;
    logic [N_SLOT-1:0][DATA_W-1:0] codes;
    logic               sup_phase;

    smseq_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    smseq_result #(.DATA_W(DATA_W), .SLOTS(N_SLOT)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .data_i  (adc_data_i),
        .codes_o (codes)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = '0;
        case (r_q.state)
            S_IDLE: if (start_i) begin
                r_d.state = S_REF_GO;
                r_d.err   = 1'b0;
            end
            S_REF_GO: begin
                r_d.state = S_REF_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = TOUT_LD;
            end
            S_REF_WAIT: if (adc_ready_i) begin
                cap[SLOT_REF] = 1'b1;
                r_d.state     = S_SETTLE;
                tmr_load      = 1'b1;
                tmr_val       = SETTLE_LD;
            end else if (tmr_zero) begin
                r_d.state = S_IDLE;
                r_d.err   = 1'b1;
            end
            S_SETTLE: if (tmr_zero) r_d.state = S_SUP_GO;
            S_SUP_GO: begin
                r_d.state = S_SUP_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = TOUT_LD;
            end
            S_SUP_WAIT: if (adc_ready_i) begin
                cap[SLOT_SUP] = 1'b1;
                r_d.state     = S_FIN;
            end else if (tmr_zero) begin
                r_d.state = S_IDLE;
                r_d.err   = 1'b1;
            end
            S_FIN:   r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: S_IDLE, err: 1'b0};
        else        r_q <= r_d;
    end

    assign sup_phase   = (r_q.state == S_SETTLE) || (r_q.state == S_SUP_GO) ||
                         (r_q.state == S_SUP_WAIT);
    assign busy_o      = (r_q.state != S_IDLE);
    assign done_o      = (r_q.state == S_FIN);
    assign err_o       = r_q.err;
    assign adc_start_o = (r_q.state == S_REF_GO) || (r_q.state == S_SUP_GO);
    assign mux_sel_o   = sup_phase ? SUP_SEL : REF_SEL;
    assign buf_en_o    = sup_phase;
    assign ctrl_o      = sup_phase ? SUP_CTRL : REF_CTRL;
    assign ref_code_o  = codes[SLOT_REF];
    assign sup_code_o  = codes[SLOT_SUP];

    // settling window watcher: cycles on the supply channel before its start pulse
    logic [CNT_W:0] settle_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   settle_seen_q <= '0;
        else if (mux_sel_o != SUP_SEL) settle_seen_q <= '0;
        else if (!adc_start_o)         settle_seen_q <= settle_seen_q + 1'b1;
    end

    p_settle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start_o && mux_sel_o == SUP_SEL) |-> settle_seen_q == SETTLE_CHK);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

    p_ref_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (adc_start_o && mux_sel_o == REF_SEL));

    p_sup_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start_o && mux_sel_o == SUP_SEL) |-> (buf_en_o && ctrl_o == SUP_CTRL));

    p_done_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(adc_ready_i));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!busy_o && !done_o));

endmodule

// File: tb/tb_supply_meas_seq.sv
module tb_supply_meas_seq;
    localparam int SETTLE = 20;
    localparam int TOUT   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        adc_ready_i = 1'b0;
    logic [11:0] adc_data_i = 12'h000;
    logic        busy_o, done_o, err_o, buf_en_o, adc_start_o;
    logic [4:0]  mux_sel_o;
    logic [15:0] ctrl_o;
    logic [11:0] ref_code_o, sup_code_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    supply_meas_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .mux_sel_o(mux_sel_o),
        .buf_en_o(buf_en_o), .ctrl_o(ctrl_o), .adc_start_o(adc_start_o),
        .adc_ready_i(adc_ready_i), .adc_data_i(adc_data_i),
        .ref_code_o(ref_code_o), .sup_code_o(sup_code_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(done_o == 0, "R1 done", done_o, 0);
        chk(err_o == 0, "R1 err", err_o, 0);
        chk(adc_start_o == 0, "R1 adc_start", adc_start_o, 0);
        chk(ref_code_o == 0 && sup_code_o == 0, "R1 codes",
            {ref_code_o, sup_code_o}, 0);
    endtask

    task automatic run_seq(input string tag, input logic [11:0] rd, input logic [11:0] sd,
                           input int kr, input int ks, input bit inj_start,
                           input bit inj_ready);
        int cnt;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o == 1, {tag, " R2 busy"}, busy_o, 1);
        chk(adc_start_o == 1, {tag, " R2 ref start"}, adc_start_o, 1);
        chk(mux_sel_o == 5'b11111, {tag, " R2 ref sel"}, mux_sel_o, 5'b11111);
        chk(ctrl_o == 16'h2A83, {tag, " R2 ref ctrl"}, ctrl_o, 16'h2A83);
        chk(buf_en_o == 0, {tag, " R3 buf off"}, buf_en_o, 0);
        chk(err_o == 0, {tag, " R10 err clear"}, err_o, 0);
        for (int i = 1; i <= kr; i++) begin
            @(negedge clk);
            chk(adc_start_o == 0, {tag, " R2 single pulse"}, adc_start_o, 0);
            start_i = inj_start && (i == 1);
            if (i == kr) begin adc_ready_i = 1'b1; adc_data_i = rd; end
        end
        @(negedge clk);
        adc_ready_i = 1'b0; start_i = 1'b0; adc_data_i = 12'hFFF;
        chk(mux_sel_o == 5'b10011, {tag, " R3 sup sel"}, mux_sel_o, 5'b10011);
        chk(buf_en_o == 1, {tag, " R3 buf on"}, buf_en_o, 1);
        chk(ref_code_o == rd, {tag, " R6/R11 ref code"}, ref_code_o, rd);
        chk(busy_o == 1, {tag, " R8 busy kept"}, busy_o, 1);
        cnt = 0;
        while (!adc_start_o && cnt < 1000) begin
            if (mux_sel_o != 5'b10011)
                chk(0, {tag, " R3 sel held"}, mux_sel_o, 5'b10011);
            adc_ready_i = inj_ready && (cnt == 2);
            adc_data_i  = ~rd;
            cnt++;
            @(negedge clk);
        end
        adc_ready_i = 1'b0;
        chk(cnt == SETTLE, {tag, " R4/R9 settle length"}, cnt, SETTLE);
        chk(ctrl_o == 16'h2AA3, {tag, " R5 sup ctrl"}, ctrl_o, 16'h2AA3);
        chk(buf_en_o == 1, {tag, " R3 buf at start"}, buf_en_o, 1);
        chk(ref_code_o == rd, {tag, " R9 ref unchanged"}, ref_code_o, rd);
        for (int i = 1; i <= ks; i++) begin
            @(negedge clk);
            chk(done_o == 0, {tag, " R7 no early done"}, done_o, 0);
            start_i = inj_start && (i == 1);
            if (i == ks) begin adc_ready_i = 1'b1; adc_data_i = sd; end
        end
        @(negedge clk);
        adc_ready_i = 1'b0; start_i = 1'b0; adc_data_i = 12'h000;
        chk(done_o == 1, {tag, " R7 done"}, done_o, 1);
        chk(sup_code_o == sd, {tag, " R6/R11 sup code"}, sup_code_o, sd);
        chk(busy_o == 1, {tag, " R7 busy with done"}, busy_o, 1);
        @(negedge clk);
        chk(done_o == 0, {tag, " R7 done one cycle"}, done_o, 0);
        chk(busy_o == 0, {tag, " R7 busy falls"}, busy_o, 0);
        chk(buf_en_o == 0, {tag, " R3 buf off after"}, buf_en_o, 0);
        @(negedge clk);
        chk(busy_o == 0 && adc_start_o == 0, {tag, " R8 no restart"},
            {busy_o, adc_start_o}, 0);
        chk(ref_code_o == rd && sup_code_o == sd, {tag, " R6 codes held"},
            {ref_code_o, sup_code_o}, {rd, sd});
    endtask

    task automatic t_timeout();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(adc_start_o == 1, "R10 ref start", adc_start_o, 1);
        for (int j = 1; j <= TOUT; j++) @(negedge clk);
        chk(busy_o == 1 && err_o == 0, "R10 still waiting", {busy_o, err_o}, 2);
        @(negedge clk);
        chk(busy_o == 0, "R10 back to idle", busy_o, 0);
        chk(err_o == 1, "R10 err set", err_o, 1);
        chk(done_o == 0, "R10 no done", done_o, 0);
        adc_ready_i = 1'b1; adc_data_i = 12'h777;
        @(negedge clk);
        adc_ready_i = 1'b0;
        chk(err_o == 1 && busy_o == 0, "R10 err held", {err_o, busy_o}, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        run_seq("basic", 12'h5A3, 12'hA5C, 1, 1, 1'b0, 1'b0);
        run_seq("busy", 12'h123, 12'h456, 3, 5, 1'b1, 1'b0);
        run_seq("stray", 12'h0F0, 12'hF0F, 2, 2, 1'b0, 1'b1);
        t_timeout();
        run_seq("recover", 12'h321, 12'h654, 2, 3, 1'b0, 1'b0);
        run_seq("R11 last", 12'hABC, 12'hDEF, TOUT, TOUT, 1'b0, 1'b0);
        finish_run();
    end

endmodule